// File: doc/BRIEF.md
# GPIO Pin Interrupt Router

This block turns pins of a wide GPIO bank into a smaller set of interrupt lines. Each of its channels picks any one pin of the bank through a source field and watches that pin in one of four sense modes: low level, high level, rising edge or falling edge. When the condition is met, the channel's status bit and its interrupt output go high. The sense modes do not include detection on both edges.

Pins are brought into the clock domain by a two-stage synchroniser. In the level modes a channel's status follows the synchronised pin. In the edge modes the status latches and stays set until software writes a one to the channel's bit in the clear register. All configuration goes over a simple 32-bit word-addressed register bus.

To retarget a channel, software first clears its enable bit. It then writes the new source and sense mode, clears any pending flag, and sets the enable bit again.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset every register reads 0 (all channels disabled, sense code 0), the status word reads 0 and every interrupt output is low.
- R2: The source field of channel n is byte n%4 of word n/4 (words 0 to 7). Bits 6:0 of the byte give the pin index and bit 7 is the enable. All 8 bits read back as written.
- R3: The sense field of channel n is bits 2*(n%16)+1:2*(n%16) of word 8+n/16 (words 8 and 9). The codes are 0 for low level, 1 for high level, 2 for rising edge and 3 for falling edge. Fields read back as written.
- R4: In high-level mode the status bit equals the selected pin level. A pin change shows on the status bit and the interrupt output on the third rising clock edge after it, not sooner.
- R5: In low-level mode the status bit is the inverse of the selected pin level, and it drops by itself once the pin returns high.
- R6: In rising-edge mode a 0-to-1 change on the selected pin sets the status bit, which stays set after the pin falls again.
- R7: In falling-edge mode a 1-to-0 change on the selected pin sets the status bit, which stays set after the pin rises again.
- R8: Word 10 reads the status of channel n at bit n. Writing a 1 to bit n of word 11 (which reads 0) clears a set status bit in the two edge modes. In the level modes such a write leaves the status unchanged.
- R9: A pin index of 64 or above never sets the status bit or the interrupt output, in any mode.
- R10: A channel whose enable is 0 never sets its status bit, whatever its pin does.
- R11: The interrupt output of a channel equals its status bit while the channel is enabled and is held low while it is disabled, even if a latched status is pending.
- R12: When an edge event and a clear of the same channel arrive in the same cycle, the status bit ends up set.
- R13: Activity on pins other than the selected one has no effect on a channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the word at bus_addr (combinational) |
| gpio_in | input | 64 | Asynchronous GPIO bank |
| irq_out | output | 32 | One interrupt line per channel |

## Verification
The bench times the synchroniser and status path. A status bit that shows up one edge early means a stage is missing, and one that shows up late means a stage too many. It checks that a clear has no effect on a level channel, so a design that clears blindly would drop an active level interrupt. It places a clear in the very cycle an edge is detected, where a design that gives the clear priority would lose the new event. It also drives every pin with a channel set to an illegal pin index and to disabled. A design that wraps the index or ignores the enable would raise a spurious interrupt there, and one that forgets the enable gate on the output would leak a latched status while the channel is disabled.

// File: rtl/gir_pkg.sv
package gir_pkg;

    localparam int REG_W         = 32;
    localparam int PIN_FIELD_W   = 7;
    localparam int SEL_FIELD_W   = PIN_FIELD_W + 1;
    localparam int SELS_PER_REG  = REG_W / SEL_FIELD_W;
    localparam int MODE_FIELD_W  = 2;
    localparam int MODES_PER_REG = REG_W / MODE_FIELD_W;

    typedef enum logic [MODE_FIELD_W-1:0] {
        SENSE_LOW  = 2'd0,
        SENSE_HIGH = 2'd1,
        SENSE_RISE = 2'd2,
        SENSE_FALL = 2'd3
    } sense_e;

    typedef struct packed {
        logic                   en;
        logic [PIN_FIELD_W-1:0] pin;
    } src_sel_t;

    function automatic logic is_edge(sense_e m);
        return (m == SENSE_RISE) || (m == SENSE_FALL);
    endfunction

    function automatic int sel_words(int nch);
        return (nch + SELS_PER_REG - 1) / SELS_PER_REG;
    endfunction

    function automatic int mode_words(int nch);
        return (nch + MODES_PER_REG - 1) / MODES_PER_REG;
    endfunction

endpackage

// File: rtl/gir_pin_sync.sv
module gir_pin_sync #(
    parameter int WIDTH  = 64,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '0;
        end else begin
            pipe[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                pipe[s] <= pipe[s-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/gir_regs.sv
module gir_regs
    import gir_pkg::*;
#(
    parameter int NUM_CH = 32,
    parameter int ADDR_W = 4
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                bus_wr,
    input  logic [ADDR_W-1:0]                   bus_addr,
    input  logic [REG_W-1:0]                    bus_wdata,
    input  logic [NUM_CH-1:0]                   stat_i,
    output logic [REG_W-1:0]                    bus_rdata,
    output src_sel_t [NUM_CH-1:0]               sel_o,
    output logic [NUM_CH-1:0][MODE_FIELD_W-1:0] mode_o,
    output logic [NUM_CH-1:0]                   clr_o
);
    localparam int MODE_BASE = sel_words(NUM_CH);
    localparam int STAT_IDX  = MODE_BASE + mode_words(NUM_CH);
    localparam int CLR_IDX   = STAT_IDX + 1;

    logic [31:0] addr_i;
    assign addr_i = 32'(bus_addr);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int SW = c / SELS_PER_REG;
        localparam int SL = SEL_FIELD_W * (c % SELS_PER_REG);
        localparam int MW = MODE_BASE + c / MODES_PER_REG;
        localparam int ML = MODE_FIELD_W * (c % MODES_PER_REG);

        logic [SEL_FIELD_W-1:0]  sel_r;
        logic [MODE_FIELD_W-1:0] mode_r;

        always_ff @(posedge clk) begin
            if (rst) begin
                sel_r  <= '0;
                mode_r <= '0;
            end else if (bus_wr) begin
                if (addr_i == 32'(SW)) sel_r  <= bus_wdata[SL +: SEL_FIELD_W];
                if (addr_i == 32'(MW)) mode_r <= bus_wdata[ML +: MODE_FIELD_W];
            end
        end

        assign sel_o[c]  = src_sel_t'(sel_r);
        assign mode_o[c] = mode_r;
    end

    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (addr_i == 32'(c / SELS_PER_REG))
                bus_rdata[SEL_FIELD_W*(c % SELS_PER_REG) +: SEL_FIELD_W] = sel_o[c];
            if (addr_i == 32'(MODE_BASE + c / MODES_PER_REG))
                bus_rdata[MODE_FIELD_W*(c % MODES_PER_REG) +: MODE_FIELD_W] = mode_o[c];
        end
        if (addr_i == 32'(STAT_IDX))
            bus_rdata[NUM_CH-1:0] = stat_i;
    end

    assign clr_o = (bus_wr && addr_i == 32'(CLR_IDX)) ? bus_wdata[NUM_CH-1:0] : '0;
endmodule

// File: rtl/gir_pin_mux.sv
module gir_pin_mux
    import gir_pkg::*;
#(
    parameter int NUM_PINS = 64
) (
    input  logic [NUM_PINS-1:0]    pins,
    input  logic [PIN_FIELD_W-1:0] pin_idx,
    output logic                   lvl,
    output logic                   legal
);
    always_comb begin
        lvl   = 1'b0;
        legal = 1'b0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (32'(pin_idx) == 32'(p)) begin
                legal = 1'b1;
                lvl   = pins[p];
            end
        end
    end
endmodule

// File: rtl/gir_channel.sv
module gir_channel
    import gir_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic                    legal,
    input  logic                    lvl,
    input  logic [MODE_FIELD_W-1:0] mode,
    input  logic                    clr,
    output logic                    evt_o,
    output logic                    stat_o,
    output logic                    irq_o
);
    sense_e m;
    logic   prev_q, stat_q, stat_d, active, hit, match;

    always_comb begin
        m      = sense_e'(mode);
        active = en && legal;
        unique case (m)
            SENSE_RISE: hit = lvl && !prev_q;
            SENSE_FALL: hit = !lvl && prev_q;
            default:    hit = 1'b0;
        endcase
        match = (m == SENSE_HIGH) ? lvl : !lvl;
        evt_o = active && hit;
        if (is_edge(m))
            stat_d = evt_o || (stat_q && !clr);
        else
            stat_d = active && match;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            stat_q <= 1'b0;
        end else begin
            prev_q <= lvl;
            stat_q <= stat_d;
        end
    end

    assign stat_o = stat_q;
    assign irq_o  = stat_q && en;
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
    import gir_pkg::*;
#(
    parameter int NUM_CH      = 32,
    parameter int NUM_PINS    = 64,
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [NUM_PINS-1:0] gpio_in,
    output logic [NUM_CH-1:0] irq_out
);
    logic [NUM_PINS-1:0]                 pins_s;
    src_sel_t [NUM_CH-1:0]               sel;
    logic [NUM_CH-1:0][MODE_FIELD_W-1:0] ch_mode;
    logic [NUM_CH-1:0]                   clr, ch_en, ch_legal, ch_lvl, ch_evt, stat;

    gir_pin_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(gpio_in), .q(pins_s)
    );

    gir_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .stat_i(stat), .bus_rdata(bus_rdata),
        .sel_o(sel), .mode_o(ch_mode), .clr_o(clr)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign ch_en[c] = sel[c].en;

        gir_pin_mux #(.NUM_PINS(NUM_PINS)) u_mux (
            .pins(pins_s), .pin_idx(sel[c].pin),
            .lvl(ch_lvl[c]), .legal(ch_legal[c])
        );

        gir_channel u_chan (
            .clk(clk), .rst(rst), .en(ch_en[c]), .legal(ch_legal[c]),
            .lvl(ch_lvl[c]), .mode(ch_mode[c]), .clr(clr[c]),
            .evt_o(ch_evt[c]), .stat_o(stat[c]), .irq_o(irq_out[c])
        );
    end
endmodule

// File: rtl/gpio_irq_router_chk.sv
module gpio_irq_router_chk
    import gir_pkg::*;
#(
    parameter int NUM_CH = 32,
    parameter int ADDR_W = 4
) (
    input logic                                clk,
    input logic                                rst,
    input logic                                bus_wr,
    input logic [ADDR_W-1:0]                   bus_addr,
    input logic [REG_W-1:0]                    bus_wdata,
    input logic [NUM_CH-1:0]                   ch_en,
    input logic [NUM_CH-1:0]                   ch_legal,
    input logic [NUM_CH-1:0]                   ch_lvl,
    input logic [NUM_CH-1:0][MODE_FIELD_W-1:0] ch_mode,
    input logic [NUM_CH-1:0]                   ch_evt,
    input logic [NUM_CH-1:0]                   stat
);
    localparam int CLR_IDX = sel_words(NUM_CH) + mode_words(NUM_CH) + 1;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        logic clr_bit, edge_m;
        assign clr_bit = bus_wr && (32'(bus_addr) == 32'(CLR_IDX)) && bus_wdata[i];
        assign edge_m  = is_edge(sense_e'(ch_mode[i]));

        a_r4_high_follows: assert property (@(posedge clk) disable iff (rst)
            (ch_en[i] && ch_legal[i] && ch_mode[i] == SENSE_HIGH) |=> (stat[i] == $past(ch_lvl[i])));
        a_r5_low_follows: assert property (@(posedge clk) disable iff (rst)
            (ch_en[i] && ch_legal[i] && ch_mode[i] == SENSE_LOW) |=> (stat[i] == !$past(ch_lvl[i])));
        a_r6_edge_holds: assert property (@(posedge clk) disable iff (rst)
            (edge_m && stat[i] && !clr_bit) |=> stat[i]);
        a_r8_edge_clears: assert property (@(posedge clk) disable iff (rst)
            (edge_m && stat[i] && clr_bit && !ch_evt[i]) |=> !stat[i]);
        a_r9_illegal_quiet: assert property (@(posedge clk) disable iff (rst)
            (!ch_legal[i] && !stat[i]) |=> !stat[i]);
        a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
            (!ch_en[i] && !stat[i]) |=> !stat[i]);
        a_r12_set_wins: assert property (@(posedge clk) disable iff (rst)
            (edge_m && ch_evt[i]) |=> stat[i]);
    end
endmodule

bind gpio_irq_router gpio_irq_router_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .ch_en(ch_en), .ch_legal(ch_legal), .ch_lvl(ch_lvl), .ch_mode(ch_mode),
    .ch_evt(ch_evt), .stat(stat)
);

// File: tb/gpio_irq_router_bench.sv
`timescale 1ns/1ps
module gpio_irq_router_bench;
    localparam int AW = 4;
    localparam int STAT_W = 10;
    localparam int CLR_W = 11;
    localparam logic [1:0] M_LOW = 2'd0, M_HIGH = 2'd1, M_RISE = 2'd2, M_FALL = 2'd3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [63:0]   pins = '0;
    logic [31:0]   irq;
    int            n_tests = 0;
    int            n_fail = 0;
    bit            done = 1'b0;

    always #4 clk = ~clk;

    gpio_irq_router u_gpio_irq_router (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gpio_in(pins), .irq_out(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bwr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a[AW-1:0]; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic brd(input int a, output logic [31:0] d);
        bus_addr = a[AW-1:0];
        #1;
        d = bus_rdata;
    endtask

    task automatic stat_bit(input int ch, output logic b);
        logic [31:0] v;
        brd(STAT_W, v);
        b = v[ch];
    endtask

    task automatic cfg(input int ch, input int pin, input bit en, input logic [1:0] mode);
        logic [31:0] v, m;
        brd(ch / 4, v);
        v[8*(ch%4) +: 8] = {1'b0, 7'(pin)};
        bwr(ch / 4, v);
        brd(8 + ch / 16, m);
        m[2*(ch%16) +: 2] = mode;
        bwr(8 + ch / 16, m);
        bwr(CLR_W, 32'd1 << ch);
        if (en) begin
            v[8*(ch%4) +: 8] = {1'b1, 7'(pin)};
            bwr(ch / 4, v);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 12; a++) begin
            brd(a, v);
            chk($sformatf("R1 word %0d after reset", a), v, 32'h0);
        end
        chk("R1 irq after reset", irq, 32'h0);
    endtask

    task automatic t_layout();
        logic [31:0] v;
        bwr(3, 32'hA5_83_01_FF);
        brd(3, v);
        chk("R2 select word readback", v, 32'hA5_83_01_FF);
        bwr(3, 32'h0);
        bwr(9, 32'hE4_1B_C6_39);
        brd(9, v);
        chk("R3 sense word readback", v, 32'hE4_1B_C6_39);
        bwr(9, 32'h0);
        brd(CLR_W, v);
        chk("R8 clear word reads zero", v, 32'h0);
    endtask

    task automatic t_level_high();
        logic b;
        cfg(5, 40, 1, M_HIGH);
        chk("R4 high idle irq", 32'(irq[5]), 32'd0);
        pins[40] = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R4 not yet after two edges", 32'(irq[5]), 32'd0);
        @(negedge clk);
        chk("R4 asserted on third edge", 32'(irq[5]), 32'd1);
        bwr(CLR_W, 32'd1 << 5);
        stat_bit(5, b);
        chk("R8 clear ignored in level mode", 32'(b), 32'd1);
        pins[40] = 1'b0;
        repeat (3) @(negedge clk);
        stat_bit(5, b);
        chk("R4 follows pin low", 32'(b), 32'd0);
    endtask

    task automatic t_level_low();
        logic b;
        pins[3] = 1'b1;
        cfg(17, 3, 1, M_LOW);
        stat_bit(17, b);
        chk("R5 low mode pin high", 32'(b), 32'd0);
        pins[3] = 1'b0;
        repeat (3) @(negedge clk);
        chk("R5 low mode pin low irq", 32'(irq[17]), 32'd1);
        pins[3] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R5 low mode self clears", 32'(irq[17]), 32'd0);
    endtask

    task automatic t_rise();
        logic b;
        logic [31:0] v;
        cfg(31, 63, 1, M_RISE);
        pins[63] = 1'b1;
        @(negedge clk);
        pins[63] = 1'b0;
        repeat (4) @(negedge clk);
        stat_bit(31, b);
        chk("R6 rise latched after pulse", 32'(b), 32'd1);
        brd(7, v);
        v[31] = 1'b0;
        bwr(7, v);
        chk("R11 disabled masks irq", 32'(irq[31]), 32'd0);
        stat_bit(31, b);
        chk("R11 status kept while disabled", 32'(b), 32'd1);
        v[31] = 1'b1;
        bwr(7, v);
        chk("R11 irq returns when enabled", 32'(irq[31]), 32'd1);
        bwr(CLR_W, 32'd1 << 31);
        chk("R8 clear in rise mode", 32'(irq[31]), 32'd0);
    endtask

    task automatic t_fall();
        logic b;
        pins[0] = 1'b1;
        cfg(0, 0, 1, M_FALL);
        stat_bit(0, b);
        chk("R7 no event while high", 32'(b), 32'd0);
        pins[0] = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 fall sets irq", 32'(irq[0]), 32'd1);
        pins[0] = 1'b1;
        repeat (4) @(negedge clk);
        chk("R7 fall holds after rise", 32'(irq[0]), 32'd1);
        bwr(CLR_W, 32'd1);
        chk("R8 clear in fall mode", 32'(irq[0]), 32'd0);
        pins[0] = 1'b0;
    endtask

    task automatic t_mux();
        cfg(8, 12, 1, M_RISE);
        pins = ~(64'd1 << 12);
        repeat (4) @(negedge clk);
        pins = '0;
        repeat (4) @(negedge clk);
        chk("R13 other pins ignored", 32'(irq[8]), 32'd0);
    endtask

    task automatic t_illegal();
        logic b;
        pins = '0;
        cfg(9, 64, 1, M_LOW);
        stat_bit(9, b);
        chk("R9 index 64 low mode", 32'(b), 32'd0);
        pins = '1;
        cfg(9, 127, 1, M_HIGH);
        stat_bit(9, b);
        chk("R9 index 127 high mode", 32'(b), 32'd0);
        pins = '0;
        cfg(9, 100, 1, M_RISE);
        pins = '1;
        repeat (4) @(negedge clk);
        chk("R9 index 100 rise irq", 32'(irq[9]), 32'd0);
        pins = '0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_disabled();
        logic b;
        cfg(10, 20, 0, M_RISE);
        pins[20] = 1'b1;
        repeat (4) @(negedge clk);
        pins[20] = 1'b0;
        repeat (4) @(negedge clk);
        stat_bit(10, b);
        chk("R10 disabled rise", 32'(b), 32'd0);
        cfg(10, 20, 0, M_LOW);
        stat_bit(10, b);
        chk("R10 disabled low level", 32'(b), 32'd0);
    endtask

    task automatic t_set_wins();
        logic b;
        cfg(2, 7, 1, M_RISE);
        pins[7] = 1'b1;
        @(negedge clk);
        pins[7] = 1'b0;
        repeat (4) @(negedge clk);
        pins[7] = 1'b1;
        @(negedge clk); @(negedge clk);
        bus_wr = 1'b1; bus_addr = AW'(CLR_W); bus_wdata = 32'd1 << 2;
        @(negedge clk);
        bus_wr = 1'b0;
        stat_bit(2, b);
        chk("R12 event beats clear", 32'(b), 32'd1);
        bwr(CLR_W, 32'd1 << 2);
        stat_bit(2, b);
        chk("R8 later clear succeeds", 32'(b), 32'd0);
        pins[7] = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_layout();
        t_level_high();
        t_level_low();
        t_rise();
        t_fall();
        t_mux();
        t_illegal();
        t_disabled();
        t_set_wins();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule